// File: doc/BRIEF.md
# External Interrupt Flag Logic with Shared Control Register

This block turns two external interrupt pins into two interrupt requests. Each channel has a trigger-type bit that software sets or clears. The type bit picks falling-edge detection or low-level detection. Each channel also has a flag that hardware sets, and that flag drives the channel's request line. Before any detection, both pins pass through a synchronizer.

In edge mode the flag latches when a falling edge is seen. It clears when the processor takes that channel's vector, which the block sees as a one-cycle acknowledge strobe. Software can also clear it through a register write. In level mode the flag is not latched: it tracks the inverted synchronized pin, so it stays set for as long as the pin is held low.

Software reaches the type bits and flags through one 8-bit control register. The upper nibble of that register holds the run and overflow bits of two timers. This block only stores those four bits, writes them from software and returns them on readback.

Top module: `xint_ctrl`

## Requirements
- R1: After a synchronous reset, the readback is 8'h00 and both interrupt requests are low.
- R2: A register write loads bits 7..4 (timer1 overflow, timer1 run, timer0 overflow, timer0 run), bit 2 (int1 type) and bit 0 (int0 type) from the write data. The new values are visible on the readback from the cycle after the write.
- R3: With a type bit of 1 (edge mode), a falling pin edge sets that channel's flag. Bit 3 holds the int1 flag and bit 1 holds the int0 flag. The request rises on the third rising clock edge after the pin falls, and it stays set after the pin returns high.
- R4: With a type bit of 0 (level mode), the flag equals the inverse of the pin, delayed by three clock edges. In this mode, acknowledge strobes and register writes have no effect on the flag.
- R5: In edge mode, an acknowledge strobe for a channel clears that channel's flag in the next cycle.
- R6: In edge mode, a register write loads the flag bit from the write data: 0 clears the flag and 1 sets it.
- R7: In edge mode, a detected falling edge in the same cycle as an acknowledge or a clearing write leaves the flag set.
- R8: Each interrupt request output equals its channel's flag bit on the readback.
- R9: The two channels are independent. Pin activity, acknowledges and flag changes on one channel do not alter the other.
- R10: Without a write, the timer bits and the type bits hold their values whatever the pins and acknowledges do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_pin_i | input | 1 | Channel 0 external pin (asynchronous) |
| ext1_pin_i | input | 1 | Channel 1 external pin (asynchronous) |
| ext0_ack_i | input | 1 | Channel 0 vector-taken strobe |
| ext1_ack_i | input | 1 | Channel 1 vector-taken strobe |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| irq0_o | output | 1 | Channel 0 interrupt request |
| irq1_o | output | 1 | Channel 1 interrupt request |
| reg_rdata_o | output | 8 | Control register readback |

## Verification
The bench targets the cycle in which a detected edge meets an acknowledge or a clearing write. A design that gave priority to the clear would lose that interrupt. In level mode the bench applies acknowledges and zero writes while the pin stays low. A design that latched the level flag, or let a clear through, would drop the request too early or hold it after the pin is released. The bench also checks the exact three-edge latency, so an extra or a missing synchronizer stage shows up as a request one cycle off. Finally, it checks that activity on one channel never disturbs the other channel or the stored timer bits.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int REG_W   = 8;
  localparam int N_CH    = 2;
  localparam int TMR_LSB = 4;
  localparam int TMR_W   = REG_W - TMR_LSB;

  // Channel c: type at bit 2c, flag at bit 2c+1 (layout decoded by software)
  function automatic int type_pos(input int c);
    return 2 * c;
  endfunction

  function automatic int flag_pos(input int c);
    return 2 * c + 1;
  endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic prv_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[LEN-2:0], d_i};
  end

  assign lvl_o = sh_q[STAGES-1];
  assign prv_o = sh_q[STAGES];
endmodule

// File: rtl/xint_chan.sv
module xint_chan (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic prv_i,
  input  logic ack_i,
  input  logic we_i,
  input  logic wtype_i,
  input  logic wflag_i,
  output logic type_o,
  output logic flag_o
);
  logic type_q, flag_q, flag_d, fall;

  assign fall = prv_i & ~lvl_i;

  always_comb begin
    if (!type_q)   flag_d = ~lvl_i;
    else if (fall) flag_d = 1'b1;
    else if (ack_i) flag_d = 1'b0;
    else if (we_i) flag_d = wflag_i;
    else           flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (we_i) type_q <= wtype_i;
    end
  end

  assign type_o = type_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/xint_tmrbits.sv
module xint_tmrbits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] bits_o
);
  always_ff @(posedge clk) begin
    if (rst)       bits_o <= '0;
    else if (we_i) bits_o <= wdata_i;
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext0_pin_i,
  input  logic             ext1_pin_i,
  input  logic             ext0_ack_i,
  input  logic             ext1_ack_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             irq0_o,
  output logic             irq1_o,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic [N_CH-1:0]  pins, acks, sync_lvl, sync_prv, types, flags;
  logic [TMR_W-1:0] tmr;

  assign pins = {ext1_pin_i, ext0_pin_i};
  assign acks = {ext1_ack_i, ext0_ack_i};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_i(pins[c]),
      .lvl_o(sync_lvl[c]), .prv_o(sync_prv[c])
    );
    xint_chan u_chan (
      .clk(clk), .rst(rst),
      .lvl_i(sync_lvl[c]), .prv_i(sync_prv[c]),
      .ack_i(acks[c]), .we_i(reg_we_i),
      .wtype_i(reg_wdata_i[type_pos(c)]),
      .wflag_i(reg_wdata_i[flag_pos(c)]),
      .type_o(types[c]), .flag_o(flags[c])
    );
    assign reg_rdata_o[type_pos(c)] = types[c];
    assign reg_rdata_o[flag_pos(c)] = flags[c];
  end

  xint_tmrbits #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i[REG_W-1:TMR_LSB]), .bits_o(tmr)
  );

  assign reg_rdata_o[REG_W-1:TMR_LSB] = tmr;
  assign irq0_o = flags[0];
  assign irq1_o = flags[1];
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ack,
  input logic       we,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [1:0] irq,
  input logic [1:0] lvl,
  input logic [1:0] prv
);
  assert_wr_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata[7:4] == $past(wdata[7:4]) && rdata[2] == $past(wdata[2])
            && rdata[0] == $past(wdata[0])));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(rdata[7:4]) && $stable(rdata[2]) && $stable(rdata[0])));

  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_edge_set_R3: assert property (@(posedge clk) disable iff (rst)
      (rdata[2*c] && prv[c] && !lvl[c]) |=> irq[c]);

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
      !rdata[2*c] |=> (irq[c] == !$past(lvl[c])));

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (rdata[2*c] && ack[c] && !(prv[c] && !lvl[c])) |=> !irq[c]);

    assert_sw_write_R6: assert property (@(posedge clk) disable iff (rst)
      (rdata[2*c] && we && !ack[c] && !(prv[c] && !lvl[c]))
        |=> (irq[c] == $past(wdata[2*c+1])));

    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (rst)
      irq[c] == rdata[2*c+1]);
  end
endmodule

bind xint_ctrl xint_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ack(acks), .we(reg_we_i), .wdata(reg_wdata_i),
  .rdata(reg_rdata_o), .irq({irq1_o, irq0_o}), .lvl(sync_lvl), .prv(sync_prv)
);

// File: tb/xint_ctrl_tb.sv
module xint_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin0 = 1'b1, pin1 = 1'b1, ack0 = 1'b0, ack1 = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic irq0, irq1;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xint_ctrl dut_i (
    .clk(clk), .rst(rst), .ext0_pin_i(pin0), .ext1_pin_i(pin1),
    .ext0_ack_i(ack0), .ext1_ack_i(ack1), .reg_we_i(we), .reg_wdata_i(wdata),
    .irq0_o(irq0), .irq1_o(irq1), .reg_rdata_o(rdata)
  );

  // Reference model built from the requirements
  logic [1:0] m_s1, m_s2, m_s3, m_typ, m_flag;
  logic [3:0] m_tmr;

  function automatic logic model_flag(input logic typ, prv, lvl, ack, wr, wbit, cur);
    if (!typ) return ~lvl;          // level mode follows pin (R4)
    if (prv && !lvl) return 1'b1;   // edge wins (R3, R7)
    if (ack) return 1'b0;           // R5
    if (wr) return wbit;            // R6
    return cur;
  endfunction

  function automatic logic [7:0] model_rd();
    return {m_tmr, m_flag[1], m_typ[1], m_flag[0], m_typ[0]};
  endfunction

  always @(posedge clk) begin
    logic [1:0] nf;
    if (rst) begin
      m_s1 = 2'b11; m_s2 = 2'b11; m_s3 = 2'b11;
      m_typ = 2'b00; m_flag = 2'b00; m_tmr = 4'h0;
    end else begin
      nf[0] = model_flag(m_typ[0], m_s3[0], m_s2[0], ack0, we, wdata[1], m_flag[0]);
      nf[1] = model_flag(m_typ[1], m_s3[1], m_s2[1], ack1, we, wdata[3], m_flag[1]);
      m_flag = nf;
      if (we) begin
        m_typ = {wdata[2], wdata[0]};
        m_tmr = wdata[7:4];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = {pin1, pin0};
    end
  end

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on && !rst) begin
      total++;
      if (rdata !== model_rd() || irq0 !== m_flag[0] || irq1 !== m_flag[1]) begin
        bad++;
        $display("FAIL R3/R4/R5/R6/R7 model: rd=%h irq=%b%b exp rd=%h irq=%b",
                 rdata, irq1, irq0, model_rd(), m_flag);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'd1234));
    wait_n(3);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset irq", {irq1, irq0}, 2'b00);
    model_on = 1;

    wr(8'hF5);
    chk("R2 write load", rdata, 8'hF5);

    // R3: edge on channel 0, exact latency
    @(negedge clk); pin0 = 1'b0;
    wait_n(2);
    chk("R3 not yet at edge 2", irq0, 1'b0);
    wait_n(1);
    chk("R3 set at edge 3", irq0, 1'b1);
    chk("R8 irq0 equals bit1", rdata[1], 1'b1);
    chk("R9 channel1 untouched", irq1, 1'b0);
    pin0 = 1'b1;
    wait_n(4);
    chk("R3 latched after pin high", irq0, 1'b1);

    // R5: acknowledge clears
    ack0 = 1'b1; @(negedge clk); ack0 = 1'b0;
    chk("R5 ack clears", irq0, 1'b0);

    // R6: software set and clear
    wr(8'hF7);
    chk("R6 write sets flag", irq0, 1'b1);
    wr(8'hF5);
    chk("R6 write clears flag", irq0, 1'b0);

    // R7: edge meets acknowledge
    @(negedge clk); pin0 = 1'b0;
    wait_n(2); ack0 = 1'b1;
    @(negedge clk); ack0 = 1'b0;
    chk("R7 edge beats ack", irq0, 1'b1);
    pin0 = 1'b1;
    ack0 = 1'b1; @(negedge clk); ack0 = 1'b0;
    wait_n(3);
    chk("R5 cleared before R7 write case", irq0, 1'b0);

    // R7: edge meets clearing write
    @(negedge clk); pin0 = 1'b0;
    wait_n(2); we = 1'b1; wdata = 8'hF5;
    @(negedge clk); we = 1'b0;
    chk("R7 edge beats write clear", irq0, 1'b1);
    pin0 = 1'b1;
    wait_n(3);

    // R4: level mode on channel 1
    wr(8'hF3);
    chk("R2 type1 cleared", rdata, 8'hF3);
    @(negedge clk); pin1 = 1'b0;
    wait_n(3);
    chk("R4 level sets irq1", irq1, 1'b1);
    ack1 = 1'b1; @(negedge clk); ack1 = 1'b0;
    chk("R4 ack ignored in level", irq1, 1'b1);
    wr(8'hF3 & 8'hF7);
    chk("R4 write ignored in level", irq1, 1'b1);
    chk("R9 channel0 unchanged", irq0, 1'b1);
    pin1 = 1'b1;
    wait_n(3);
    chk("R4 follows pin release", irq1, 1'b0);

    // R10: no writes, busy pins
    keep = rdata;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      pin0 = 1'($urandom); pin1 = 1'($urandom);
      ack0 = 1'($urandom); ack1 = 1'($urandom);
    end
    @(negedge clk); ack0 = 1'b0; ack1 = 1'b0;
    chk("R10 timer and type bits hold", {rdata[7:4], rdata[2], rdata[0]},
        {keep[7:4], keep[2], keep[0]});

    // Random phase checked by model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      pin0 = ($urandom % 4) != 0 ? pin0 : ~pin0;
      pin1 = ($urandom % 4) != 0 ? pin1 : ~pin1;
      ack0 = ($urandom % 6) == 0;
      ack1 = ($urandom % 6) == 0;
      we   = ($urandom % 8) == 0;
      wdata = 8'($urandom);
    end
    @(negedge clk); we = 1'b0; ack0 = 1'b0; ack1 = 1'b0;
    wait_n(2);

    // R1: reset mid-run
    rst = 1'b1; wait_n(2);
    chk("R1 reset again", {rdata, irq1, irq0}, 10'h000);
    rst = 1'b0; wait_n(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule